// File: doc/BRIEF.md
# HALT/STOP Power Mode Controller

This block moves a small microcontroller between three operating modes: normal execution, a light sleep (HALT), in which only the processor clock is gated, and a deep sleep (STOP), in which the oscillator and the peripheral clocks are also switched off. It drives a clock enable for the processor, one for the oscillator, and one each for the LCD driver, the base timer and the general timer. When a sleep ends, it raises a one-cycle wake event so that the processor services the interrupt and then continues after the sleep instruction.

In deep sleep, the oscillator, the LCD driver and the base timer keep running only when their enable bits were set and a static two-bit clock option allowed it, both sampled when the sleep began. The base-timer interrupt can end a deep sleep only when the base timer kept running. A port interrupt always ends it. A deep-sleep exit first passes through a warm-up phase: the block requests warm-up and keeps the processor gated until a warm-up-done input arrives.

Top module: `pwr_mode_ctl`

## Requirements
- R1: During and after synchronous active-low reset with idle inputs, the block is in run mode: all five clock enables are 1, and warm_req and wake_evt are 0.
- R2: halt_req in run mode, with no interrupt line high, makes cpu_clk_en 0 from the next cycle, while osc_clk_en, lcd_clk_en, btm_clk_en and tmr_clk_en stay 1.
- R3: In HALT, any high interrupt line (irq_port, irq_btm or any bit of irq_misc) returns the block to run mode in the next cycle, with cpu_clk_en 1 and wake_evt 1.
- R4: stop_req accepted in run mode makes cpu_clk_en and tmr_clk_en 0 from the next cycle. Let keep = (clk_opt is 2'b00 or 2'b01). Then osc_clk_en = osc_en & keep, lcd_clk_en = lcd_en & osc_en & keep, and btm_clk_en = btm_en & osc_en & keep, all taken on the stop_req cycle.
- R5: These retention decisions are held through STOP and warm-up. Later changes to osc_en, lcd_en, btm_en or clk_opt do not change the outputs.
- R6: In STOP, a wake source moves the block to warm-up in the next cycle: warm_req 1, osc_clk_en 1, cpu_clk_en 0, tmr_clk_en 0, and lcd_clk_en and btm_clk_en unchanged.
- R7: In STOP, irq_port always wakes. irq_btm wakes only when btm_clk_en is being held at 1. irq_misc never wakes. An ignored interrupt leaves all outputs unchanged.
- R8: In warm-up, the block waits while warm_done is 0. In the cycle after warm_done is 1, it is in run mode with all enables 1, warm_req 0 and wake_evt 1.
- R9: If a wake source is already high when a sleep strobe arrives, the block stays in run mode with no wake event. For halt_req this is any interrupt line; for stop_req it is the STOP wake rule of R7 applied to the current enables and option.
- R10: When halt_req and stop_req are high together, stop_req takes priority. Sleep strobes are ignored outside run mode.
- R11: wake_evt is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | HALT instruction strobe |
| stop_req | input | 1 | STOP instruction strobe |
| irq_port | input | 1 | Port interrupt request |
| irq_btm | input | 1 | Base-timer interrupt request |
| irq_misc | input | N_MISC | Other interrupt requests (general timer and others) |
| osc_en | input | 1 | Oscillator enable bit |
| lcd_en | input | 1 | LCD driver enable bit |
| btm_en | input | 1 | Base timer enable bit |
| clk_opt | input | 2 | Static clock-selection option |
| warm_done | input | 1 | Warm-up timer finished |
| cpu_clk_en | output | 1 | Processor clock enable |
| osc_clk_en | output | 1 | Oscillator enable |
| lcd_clk_en | output | 1 | LCD driver clock enable |
| btm_clk_en | output | 1 | Base timer clock enable |
| tmr_clk_en | output | 1 | General timer clock enable |
| warm_req | output | 1 | Warm-up request |
| wake_evt | output | 1 | One-cycle wake event to the processor |

## Verification
The bench attacks the STOP retention rules. It uses option 2'b10 with every enable set, and an oscillator that is off while the base timer is on. A design that ignored the option or the oscillator dependency would leave a clock running or wake on irq_btm. It changes the enable bits during STOP and checks that the held values survive into warm-up, which catches a design that reads the enables live. It raises an interrupt together with a sleep strobe, which a design without the pending check would turn into a sleep with no one left to wake it. It also holds warm_done low for several cycles, which catches a design that releases the processor clock early.

// File: rtl/pwr_mode_pkg.sv
// Shared types for the power mode controller.
package pwr_mode_pkg;
    localparam int CKOPT_W = 2;

    typedef enum logic [1:0] {
        MD_RUN  = 2'd0,
        MD_HALT = 2'd1,
        MD_STOP = 2'd2,
        MD_WARM = 2'd3
    } pmode_t;

    typedef struct packed {
        logic osc;
        logic lcd;
        logic btm;
    } keep_t;

    // Clock options 0 and 1 allow the oscillator domain to survive STOP.
    function automatic logic opt_allows_keep(input logic [CKOPT_W-1:0] opt);
        return (opt == CKOPT_W'(0)) || (opt == CKOPT_W'(1));
    endfunction
endpackage

// File: rtl/pwr_keep_sample.sv
// Retention sampler: computes which clocks may survive STOP from the live
// enables and option, and freezes that decision when STOP is entered.
// Assumes capture is a single-cycle pulse issued by the sequencer.
module pwr_keep_sample
    import pwr_mode_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic               osc_en,
    input  logic               lcd_en,
    input  logic               btm_en,
    input  logic [CKOPT_W-1:0] clk_opt,
    output keep_t              keep_now,
    output keep_t              keep_q
);
    logic opt_ok;

    // Candidate retention from current settings.
    always_comb begin
        opt_ok       = opt_allows_keep(clk_opt);
        keep_now.osc = osc_en & opt_ok;
        keep_now.lcd = lcd_en & osc_en & opt_ok;
        keep_now.btm = btm_en & osc_en & opt_ok;
    end

    // Freeze retention on STOP entry.
    always_ff @(posedge clk) begin
        if (!rst_n)       keep_q <= '0;
        else if (capture) keep_q <= keep_now;
    end
endmodule

// File: rtl/pwr_wake_eval.sv
// Wake evaluation: merges the interrupt lines and decides which of them
// may end a HALT or a STOP. Purely combinational.
module pwr_wake_eval #(
    parameter int N_MISC = 4
) (
    input  logic              irq_port,
    input  logic              irq_btm,
    input  logic [N_MISC-1:0] irq_misc,
    input  logic              keep_now_btm,
    input  logic              keep_q_btm,
    output logic              any_irq,
    output logic              stop_wake_pend,
    output logic              stop_wake_live
);
    logic [N_MISC:0] misc_chain;

    assign misc_chain[0] = 1'b0;
    // OR chain over the miscellaneous interrupt lines.
    for (genvar g = 0; g < N_MISC; g++) begin : g_misc_or
        assign misc_chain[g+1] = misc_chain[g] | irq_misc[g];
    end

    // Wake qualification for both sleep depths.
    always_comb begin
        any_irq        = irq_port | irq_btm | misc_chain[N_MISC];
        stop_wake_pend = irq_port | (irq_btm & keep_now_btm);
        stop_wake_live = irq_port | (irq_btm & keep_q_btm);
    end
endmodule

// File: rtl/pwr_seq_fsm.sv
// Mode sequencer: RUN / HALT / STOP / WARM state machine with the wake
// event pulse. Assumes wake qualifiers are already computed upstream.
module pwr_seq_fsm
    import pwr_mode_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   halt_req,
    input  logic   stop_req,
    input  logic   any_irq,
    input  logic   stop_wake_pend,
    input  logic   stop_wake_live,
    input  logic   warm_done,
    output pmode_t mode,
    output logic   capture,
    output logic   wake_evt
);
    pmode_t mode_d;
    logic   wake_d;

    // Next-state selection.
    always_comb begin
        mode_d  = mode;
        wake_d  = 1'b0;
        capture = 1'b0;
        unique case (mode)
            MD_RUN: begin
                if (stop_req) begin
                    if (!stop_wake_pend) begin
                        mode_d  = MD_STOP;
                        capture = 1'b1;
                    end
                end else if (halt_req && !any_irq) begin
                    mode_d = MD_HALT;
                end
            end
            MD_HALT: if (any_irq) begin
                mode_d = MD_RUN;
                wake_d = 1'b1;
            end
            MD_STOP: if (stop_wake_live) mode_d = MD_WARM;
            MD_WARM: if (warm_done) begin
                mode_d = MD_RUN;
                wake_d = 1'b1;
            end
            default: mode_d = MD_RUN;
        endcase
    end

    // State and wake pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MD_RUN;
            wake_evt <= 1'b0;
        end else begin
            mode     <= mode_d;
            wake_evt <= wake_d;
        end
    end

    a_r3_halt_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_HALT && any_irq) |=> (mode == MD_RUN && wake_evt));
    a_r7_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_STOP && !stop_wake_live) |=> (mode == MD_STOP));
    a_r8_warm_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_WARM && !warm_done) |=> (mode == MD_WARM && !wake_evt));
    a_r9_pending_run: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_RUN && halt_req && any_irq && !(stop_req && !stop_wake_pend))
        |=> (mode == MD_RUN && !wake_evt));
    a_r10_stop_first: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_RUN && stop_req && halt_req && !stop_wake_pend) |=> (mode == MD_STOP));
    a_r11_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> !wake_evt);
endmodule

// File: rtl/pwr_clk_decode.sv
// Clock enable decode: maps the mode and frozen retention onto the
// processor, oscillator and peripheral enables.
module pwr_clk_decode
    import pwr_mode_pkg::*;
(
    input  pmode_t mode,
    input  keep_t  keep_q,
    output logic   cpu_clk_en,
    output logic   osc_clk_en,
    output logic   lcd_clk_en,
    output logic   btm_clk_en,
    output logic   tmr_clk_en,
    output logic   warm_req
);
    logic awake, deep;

    // Enable decode per mode.
    always_comb begin
        awake      = (mode == MD_RUN) || (mode == MD_HALT);
        deep       = (mode == MD_STOP) || (mode == MD_WARM);
        cpu_clk_en = (mode == MD_RUN);
        warm_req   = (mode == MD_WARM);
        osc_clk_en = awake || (mode == MD_WARM) || (deep && keep_q.osc);
        lcd_clk_en = awake || (deep && keep_q.lcd);
        btm_clk_en = awake || (deep && keep_q.btm);
        tmr_clk_en = awake;
    end
endmodule

// File: rtl/pwr_mode_ctl.sv
// HALT/STOP power mode controller top. Assumes halt_req/stop_req are
// single-cycle strobes and interrupt lines are levels held until serviced.
module pwr_mode_ctl
    import pwr_mode_pkg::*;
#(
    parameter int N_MISC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_req,
    input  logic              stop_req,
    input  logic              irq_port,
    input  logic              irq_btm,
    input  logic [N_MISC-1:0] irq_misc,
    input  logic              osc_en,
    input  logic              lcd_en,
    input  logic              btm_en,
    input  logic [1:0]        clk_opt,
    input  logic              warm_done,
    output logic              cpu_clk_en,
    output logic              osc_clk_en,
    output logic              lcd_clk_en,
    output logic              btm_clk_en,
    output logic              tmr_clk_en,
    output logic              warm_req,
    output logic              wake_evt
);
    pmode_t mode;
    keep_t  keep_now, keep_q;
    logic   capture, any_irq, stop_wake_pend, stop_wake_live;

    pwr_keep_sample u_keep (
        .clk(clk), .rst_n(rst_n), .capture(capture),
        .osc_en(osc_en), .lcd_en(lcd_en), .btm_en(btm_en), .clk_opt(clk_opt),
        .keep_now(keep_now), .keep_q(keep_q)
    );

    pwr_wake_eval #(.N_MISC(N_MISC)) u_wake (
        .irq_port(irq_port), .irq_btm(irq_btm), .irq_misc(irq_misc),
        .keep_now_btm(keep_now.btm), .keep_q_btm(keep_q.btm),
        .any_irq(any_irq), .stop_wake_pend(stop_wake_pend),
        .stop_wake_live(stop_wake_live)
    );

    pwr_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
        .any_irq(any_irq), .stop_wake_pend(stop_wake_pend),
        .stop_wake_live(stop_wake_live), .warm_done(warm_done),
        .mode(mode), .capture(capture), .wake_evt(wake_evt)
    );

    pwr_clk_decode u_dec (
        .mode(mode), .keep_q(keep_q),
        .cpu_clk_en(cpu_clk_en), .osc_clk_en(osc_clk_en), .lcd_clk_en(lcd_clk_en),
        .btm_clk_en(btm_clk_en), .tmr_clk_en(tmr_clk_en), .warm_req(warm_req)
    );

    a_r5_keep_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_STOP || mode == MD_WARM) |=> $stable(keep_q));
    a_r6_warm_osc: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_STOP && stop_wake_live) |=> (warm_req && osc_clk_en && !cpu_clk_en));
endmodule

// File: tb/pwr_mode_ctl_test.sv
// Scoreboard bench: the driver pushes expected output vectors into a queue,
// the monitor pops each one on the cycle it falls due and compares.
module pwr_mode_ctl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_req = 0, stop_req = 0, irq_port = 0, irq_btm = 0;
    logic [3:0] irq_misc = '0;
    logic osc_en = 0, lcd_en = 0, btm_en = 0, warm_done = 0;
    logic [1:0] clk_opt = 2'b00;
    logic cpu_clk_en, osc_clk_en, lcd_clk_en, btm_clk_en, tmr_clk_en, warm_req, wake_evt;

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        int         due;
        logic [6:0] exp;
        string      tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    // Vector order: {cpu, osc, lcd, btm, tmr, warm_req, wake_evt}
    localparam logic [6:0] E_RUN  = 7'b1111100;
    localparam logic [6:0] E_HALT = 7'b0111100;
    localparam logic [6:0] E_WAKE = 7'b1111101;

    always #4 clk = ~clk;

    pwr_mode_ctl #(.N_MISC(4)) uut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
        .irq_port(irq_port), .irq_btm(irq_btm), .irq_misc(irq_misc),
        .osc_en(osc_en), .lcd_en(lcd_en), .btm_en(btm_en), .clk_opt(clk_opt),
        .warm_done(warm_done),
        .cpu_clk_en(cpu_clk_en), .osc_clk_en(osc_clk_en), .lcd_clk_en(lcd_clk_en),
        .btm_clk_en(btm_clk_en), .tmr_clk_en(tmr_clk_en), .warm_req(warm_req),
        .wake_evt(wake_evt)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Driver side: expectation for the outputs after the next rising edge.
    task automatic expect_next(input logic [6:0] e, input string tag);
        exp_item_t it;
        it.due = cyc + 1;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic clear_pulses();
        halt_req = 0; stop_req = 0; irq_port = 0; irq_btm = 0;
        irq_misc = '0; warm_done = 0;
    endtask

    // Monitor: compare at the falling edge once an item is due.
    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            exp_item_t it;
            logic [6:0] act;
            it  = sb_q.pop_front();
            act = {cpu_clk_en, osc_clk_en, lcd_clk_en, btm_clk_en, tmr_clk_en, warm_req, wake_evt};
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %b expected %b", it.tag, act, it.exp);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc == 5000) begin
            n_bad++;
            $display("FAIL watchdog: got cycle %0d expected end before it", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, during and after reset
        @(negedge clk); expect_next(E_RUN, "R1 in reset");
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1; expect_next(E_RUN, "R1 after reset");

        // R2 / R3 / R11: HALT, wake by misc irq
        @(negedge clk); halt_req = 1; expect_next(E_HALT, "R2 enter halt");
        @(negedge clk); clear_pulses(); expect_next(E_HALT, "R2 stay halt");
        @(negedge clk); irq_misc = 4'b0100; expect_next(E_WAKE, "R3 misc wake");
        @(negedge clk); clear_pulses(); expect_next(E_RUN, "R11 pulse ends");

        // R9: HALT blocked by pending port irq
        @(negedge clk); halt_req = 1; irq_port = 1; expect_next(E_RUN, "R9 halt blocked");
        @(negedge clk); clear_pulses(); expect_next(E_RUN, "R9 no wake");

        // R3: HALT, wake by port irq
        @(negedge clk); halt_req = 1; expect_next(E_HALT, "R2 enter halt again");
        @(negedge clk); clear_pulses(); irq_port = 1; expect_next(E_WAKE, "R3 port wake");
        @(negedge clk); clear_pulses(); expect_next(E_RUN, "R11 pulse ends 2");

        // R4 / R5 / R6 / R7 / R8: STOP option 00 with all enables
        @(negedge clk); osc_en = 1; lcd_en = 1; btm_en = 1; clk_opt = 2'b00;
        stop_req = 1; expect_next(7'b0111000, "R4 stop keep all");
        @(negedge clk); clear_pulses(); osc_en = 0; lcd_en = 0; btm_en = 0; clk_opt = 2'b11;
        expect_next(7'b0111000, "R5 held after enable change");
        @(negedge clk); irq_misc = 4'b0001; halt_req = 1; expect_next(7'b0111000, "R7 misc ignored R10");
        @(negedge clk); clear_pulses(); irq_btm = 1; expect_next(7'b0111010, "R6 btm wake to warm");
        @(negedge clk); clear_pulses(); expect_next(7'b0111010, "R8 warm wait");
        @(negedge clk); expect_next(7'b0111010, "R8 warm wait 2");
        @(negedge clk); warm_done = 1; expect_next(E_WAKE, "R8 warm done");
        @(negedge clk); clear_pulses(); expect_next(E_RUN, "R11 pulse ends 3");

        // R4 / R7: option 10 drops everything, btm irq ignored
        @(negedge clk); osc_en = 1; lcd_en = 1; btm_en = 1; clk_opt = 2'b10;
        stop_req = 1; expect_next(7'b0000000, "R4 option 10 stops all");
        @(negedge clk); clear_pulses(); irq_btm = 1; expect_next(7'b0000000, "R7 btm ignored");
        @(negedge clk); clear_pulses(); warm_done = 1; expect_next(7'b0000000, "R8 done ignored in stop");
        @(negedge clk); clear_pulses(); irq_port = 1; expect_next(7'b0100010, "R6 port wake");
        @(negedge clk); clear_pulses(); warm_done = 1; expect_next(E_WAKE, "R8 wake after warm");
        @(negedge clk); clear_pulses(); expect_next(E_RUN, "R1 back in run");

        // R9: STOP blocked by qualifying btm irq; then option 01 partial keep
        @(negedge clk); osc_en = 1; lcd_en = 0; btm_en = 1; clk_opt = 2'b01;
        stop_req = 1; irq_btm = 1; expect_next(E_RUN, "R9 stop blocked");
        @(negedge clk); clear_pulses(); expect_next(E_RUN, "R9 still run");
        @(negedge clk); stop_req = 1; expect_next(7'b0101000, "R4 option 01 partial");
        @(negedge clk); clear_pulses(); stop_req = 1; expect_next(7'b0101000, "R10 strobe ignored in stop");
        @(negedge clk); clear_pulses(); irq_btm = 1; expect_next(7'b0101010, "R7 btm wakes when kept");
        @(negedge clk); clear_pulses(); warm_done = 1; expect_next(E_WAKE, "R8 wake");
        @(negedge clk); clear_pulses(); expect_next(E_RUN, "R11 pulse ends 4");

        // R4 / R7 / R9: oscillator off means btm not kept, btm irq cannot block or wake
        @(negedge clk); osc_en = 0; lcd_en = 1; btm_en = 1; clk_opt = 2'b00;
        stop_req = 1; irq_btm = 1; expect_next(7'b0000000, "R9 btm not qualifying");
        @(negedge clk); stop_req = 0; expect_next(7'b0000000, "R7 btm held ignored");
        @(negedge clk); clear_pulses(); irq_port = 1; expect_next(7'b0100010, "R6 port wake 2");
        @(negedge clk); clear_pulses(); warm_done = 1; expect_next(E_WAKE, "R8 wake 2");
        @(negedge clk); clear_pulses(); expect_next(E_RUN, "R11 pulse ends 5");

        // R10: halt and stop together, stop wins
        @(negedge clk); osc_en = 1; lcd_en = 1; btm_en = 1; clk_opt = 2'b00;
        halt_req = 1; stop_req = 1; expect_next(7'b0111000, "R10 stop priority");
        @(negedge clk); clear_pulses(); irq_port = 1; expect_next(7'b0111010, "R6 warm lcd kept");
        @(negedge clk); clear_pulses(); warm_done = 1; expect_next(E_WAKE, "R8 wake 3");
        @(negedge clk); clear_pulses(); expect_next(E_RUN, "R11 pulse ends 6");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule